// File: doc/BRIEF.md
# Dual-Port Serial Bit-Rate Tick Generator

This block makes the timing strobes that two serial ports use to sample and send bits. Each port has a 10-bit reload value. Software loads it through two byte-wide writes. One write fills the upper two bits and the other fills the lower eight bits. A free-running counter starts at the reload value and counts up to all ones. When it overflows it reloads. A post-divider then turns the overflows into an oversampling tick at sixteen times the bit rate. A further divide by sixteen gives a bit-period strobe.

Port 0 has two extra features:
- A rate-doubling control that halves its post-divider.
- A second source: an 8-bit timer that counts on a divide-by-12 prescaled clock, reloads from its own byte on overflow, and feeds a divide-by-2 post-divider (also halved by the doubling control).

Port 1 always uses its own generator and has no doubling. All outputs are single-cycle strobes taken straight from registers.

For a system clock f:
- Port 0 generator bit rate is f·2^dbl / (64·(1024−R0)).
- Port 1 bit rate is f / (32·(1024−R1)).
- Port 0 timer bit rate is f·2^dbl / (384·(256−T)).

Top module: `brg_baud_gen`

## Requirements
- R1: A port's 10-bit reload value is {hi[1:0], lo[7:0]}. A hi write stores only `wr_data[1:0]`, and bits 7:2 of that write are ignored.
- R2: Reset sets both reload values and the timer reload byte to zero, and holds all four strobes low. After reset, port 0 ticks every 4096 clocks and port 1 every 2048 clocks.
- R3: With `p0_use_tmr`=0, the interval between `p0_tick16` strobes is 4·(1024−R0) clocks. With `p0_dbl`=1 it is 2·(1024−R0).
- R4: The interval between `p1_tick16` strobes is 2·(1024−R1) clocks, whatever the values of `p0_dbl` and `p0_use_tmr`.
- R5: With `p0_use_tmr`=1, the interval between `p0_tick16` strobes is 24·(256−T) clocks, or 12·(256−T) clocks with `p0_dbl`=1. T is the timer reload byte.
- R6: A reload write changes nothing in the current count. The new value is loaded only at the next counter overflow.
- R7: Each tick strobe is high for exactly one clock.
- R8: `pN_bit` pulses on every 16th `pN_tick16` strobe, in the same cycle as that strobe, so the bit period is 16 tick intervals.
- R9: A reload of 1023 gives the fastest rate: an overflow every counted clock. That is a 4-clock tick interval on port 0 (2 with doubling) and a 2-clock interval on port 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 8 | Write data for the reload registers |
| p0_hi_we | input | 1 | Write port 0 reload bits 9:8 from wr_data[1:0] |
| p0_lo_we | input | 1 | Write port 0 reload bits 7:0 |
| p1_hi_we | input | 1 | Write port 1 reload bits 9:8 from wr_data[1:0] |
| p1_lo_we | input | 1 | Write port 1 reload bits 7:0 |
| tmr_we | input | 1 | Write the 8-bit timer reload byte |
| p0_dbl | input | 1 | Port 0 rate doubling |
| p0_use_tmr | input | 1 | Port 0 source: 0 = generator, 1 = timer |
| p0_tick16 | output | 1 | Port 0 oversampling strobe (16× bit rate) |
| p0_bit | output | 1 | Port 0 bit-period strobe |
| p1_tick16 | output | 1 | Port 1 oversampling strobe (16× bit rate) |
| p1_bit | output | 1 | Port 1 bit-period strobe |

## Verification
A new setting does not show up in a fixed number of cycles. A reload write only lands at the next overflow, and a change of divider limit leaves a partly used divider count. The first interval after a write is therefore unpredictable.

The checks wait for two full strobes after the last write and measure only the interval that follows, which has to be exact. The deferred-reload check does the opposite: it times the interval right after a write to show it still follows the old reload value, then times the interval after that to show it follows the new one. The strobes come out of registers one clock after the internal overflow. Because every check compares the distance between strobes, that fixed delay cancels out.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int BRG_REL_W    = 10;
  localparam int BRG_TMR_W    = 8;
  localparam int BRG_DW       = 8;
  localparam int BRG_PRESCALE = 12;
  localparam int BRG_OVS      = 16;

  // Terminal count of a post-divider whose ratio halves when doubling is on.
  function automatic int brg_div_lim(input int base, input logic dbl);
    return dbl ? (base / 2) - 1 : base - 1;
  endfunction
endpackage

// File: rtl/brg_reload_cnt.sv
module brg_reload_cnt #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] reload_i,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf;

  always_comb begin
    ovf   = en_i & (&cnt_q);
    cnt_d = ovf ? reload_i : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_d;
  end

  assign ovf_o = ovf;
endmodule

// File: rtl/brg_strobe_div.sv
module brg_strobe_div #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_i,
  input  logic [CW-1:0] lim_i,
  output logic          stb_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hit;

  always_comb begin
    hit   = (cnt_q >= lim_i);
    cnt_d = hit ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (stb_i) cnt_q <= cnt_d;
  end

  assign stb_o = stb_i & hit;
endmodule

// File: rtl/brg_baud_gen.sv
module brg_baud_gen #(
  parameter int REL_W    = brg_pkg::BRG_REL_W,
  parameter int TMR_W    = brg_pkg::BRG_TMR_W,
  parameter int DW       = brg_pkg::BRG_DW,
  parameter int PRESCALE = brg_pkg::BRG_PRESCALE,
  parameter int OVS      = brg_pkg::BRG_OVS,
  parameter int P0_DIV   = 4,
  parameter int P1_DIV   = 2,
  parameter int TMR_DIV  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data,
  input  logic          p0_hi_we,
  input  logic          p0_lo_we,
  input  logic          p1_hi_we,
  input  logic          p1_lo_we,
  input  logic          tmr_we,
  input  logic          p0_dbl,
  input  logic          p0_use_tmr,
  output logic          p0_tick16,
  output logic          p0_bit,
  output logic          p1_tick16,
  output logic          p1_bit
);
  localparam int NPORT = 2;
  localparam int HI_W  = REL_W - DW;
  localparam int DMAX  = (P0_DIV > P1_DIV) ? P0_DIV : P1_DIV;
  localparam int DCW   = $clog2(DMAX + 1);
  localparam int TCW   = $clog2(TMR_DIV + 1);
  localparam int PCW   = $clog2(PRESCALE + 1);
  localparam int OCW   = $clog2(OVS + 1);

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int = rst_sync_q[1];

  logic [NPORT-1:0] rel_hi_we, rel_lo_we, gen_tick, src_tick, bit_stb;
  logic [NPORT-1:0] tick_q, tick_d, bit_q, bit_d;

  assign rel_hi_we = {p1_hi_we, p0_hi_we};
  assign rel_lo_we = {p1_lo_we, p0_lo_we};

  // Timer path for port 0: prescaler, 8-bit reload counter, post-divider.
  logic [TMR_W-1:0] th_q, th_d;
  logic             pre_stb, tmr_ovf, tmr_tick;
  logic [TCW-1:0]   tmr_lim;

  always_comb th_d = wr_data[TMR_W-1:0];

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)    th_q <= '0;
    else if (tmr_we) th_q <= th_d;
  end

  brg_strobe_div #(.CW(PCW)) u_prescale (
    .clk(clk), .rst_n(rst_int), .stb_i(1'b1),
    .lim_i(PCW'(PRESCALE - 1)), .stb_o(pre_stb)
  );

  brg_reload_cnt #(.W(TMR_W)) u_tmr_cnt (
    .clk(clk), .rst_n(rst_int), .en_i(pre_stb),
    .reload_i(th_q), .ovf_o(tmr_ovf)
  );

  assign tmr_lim = TCW'(brg_pkg::brg_div_lim(TMR_DIV, p0_dbl));

  brg_strobe_div #(.CW(TCW)) u_tmr_div (
    .clk(clk), .rst_n(rst_int), .stb_i(tmr_ovf),
    .lim_i(tmr_lim), .stb_o(tmr_tick)
  );

  // Per-port reload generator and oversampling divider.
  for (genvar g = 0; g < NPORT; g++) begin : g_port
    localparam int BASE = (g == 0) ? P0_DIV : P1_DIV;
    logic [REL_W-1:0] rel_q, rel_d;
    logic             dbl, ovf;
    logic [DCW-1:0]   lim;

    always_comb begin
      rel_d = rel_q;
      if (rel_lo_we[g]) rel_d[DW-1:0]    = wr_data;
      if (rel_hi_we[g]) rel_d[REL_W-1:DW] = wr_data[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_int) begin
      if (!rst_int)                        rel_q <= '0;
      else if (rel_lo_we[g] | rel_hi_we[g]) rel_q <= rel_d;
    end

    assign dbl = (g == 0) ? p0_dbl : 1'b0;
    assign lim = DCW'(brg_pkg::brg_div_lim(BASE, dbl));

    brg_reload_cnt #(.W(REL_W)) u_cnt (
      .clk(clk), .rst_n(rst_int), .en_i(1'b1),
      .reload_i(rel_q), .ovf_o(ovf)
    );

    brg_strobe_div #(.CW(DCW)) u_div (
      .clk(clk), .rst_n(rst_int), .stb_i(ovf),
      .lim_i(lim), .stb_o(gen_tick[g])
    );

    brg_strobe_div #(.CW(OCW)) u_ovs (
      .clk(clk), .rst_n(rst_int), .stb_i(src_tick[g]),
      .lim_i(OCW'(OVS - 1)), .stb_o(bit_stb[g])
    );
  end

  assign src_tick[0] = p0_use_tmr ? tmr_tick : gen_tick[0];
  assign src_tick[1] = gen_tick[1];

  // Registered strobe outputs.
  always_comb begin
    tick_d = src_tick;
    bit_d  = bit_stb;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      tick_q <= '0;
      bit_q  <= '0;
    end else begin
      tick_q <= tick_d;
      bit_q  <= bit_d;
    end
  end

  assign p0_tick16 = tick_q[0];
  assign p1_tick16 = tick_q[1];
  assign p0_bit    = bit_q[0];
  assign p1_bit    = bit_q[1];
endmodule

// File: rtl/brg_baud_gen_chk.sv
module brg_baud_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic p0_tick16,
  input logic p0_bit,
  input logic p1_tick16,
  input logic p1_bit
);
  // R2: strobes stay low while reset is applied
  assert_reset_quiet_R2: assert property (@(posedge clk)
    !rst_n |-> (!p0_tick16 && !p1_tick16 && !p0_bit && !p1_bit));

  // R7: single-cycle strobes
  assert_p0_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    p0_tick16 |=> !p0_tick16);
  assert_p1_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    p1_tick16 |=> !p1_tick16);

  // R8: bit strobe lands on a tick strobe
  assert_p0_bit_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    p0_bit |-> p0_tick16);
  assert_p1_bit_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    p1_bit |-> p1_tick16);
endmodule

bind brg_baud_gen brg_baud_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .p0_tick16(p0_tick16), .p0_bit(p0_bit),
  .p1_tick16(p1_tick16), .p1_bit(p1_bit)
);

// File: tb/brg_baud_gen_tb.sv
module brg_baud_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wr_data = '0;
  logic       p0_hi_we = 1'b0, p0_lo_we = 1'b0, p1_hi_we = 1'b0, p1_lo_we = 1'b0;
  logic       tmr_we = 1'b0, p0_dbl = 1'b0, p0_use_tmr = 1'b0;
  logic       p0_tick16, p0_bit, p1_tick16, p1_bit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  brg_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
    .p0_hi_we(p0_hi_we), .p0_lo_we(p0_lo_we),
    .p1_hi_we(p1_hi_we), .p1_lo_we(p1_lo_we),
    .tmr_we(tmr_we), .p0_dbl(p0_dbl), .p0_use_tmr(p0_use_tmr),
    .p0_tick16(p0_tick16), .p0_bit(p0_bit),
    .p1_tick16(p1_tick16), .p1_bit(p1_bit)
  );

  // {sel, dbl, rel0[10], rel1[10], th[8], exp0[16], exp1[16]}
  localparam int NV = 7;
  localparam logic [61:0] VEC [NV] = '{
    {1'b0, 1'b0, 10'd1023, 10'd1023, 8'd0,   16'd4,    16'd2},
    {1'b0, 1'b1, 10'd1023, 10'd1000, 8'd0,   16'd2,    16'd48},
    {1'b0, 1'b0, 10'd1000, 10'd1000, 8'd0,   16'd96,   16'd48},
    {1'b0, 1'b1, 10'd768,  10'd512,  8'd0,   16'd512,  16'd1024},
    {1'b1, 1'b0, 10'd1023, 10'd1020, 8'd255, 16'd24,   16'd8},
    {1'b1, 1'b1, 10'd1023, 10'd1023, 8'd250, 16'd72,   16'd2},
    {1'b1, 1'b0, 10'd1000, 10'd700,  8'd200, 16'd1344, 16'd648}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic logic sig(input int port, input bit is_bit);
    if (port == 0) return is_bit ? p0_bit : p0_tick16;
    return is_bit ? p1_bit : p1_tick16;
  endfunction

  // sel: 0 p0 hi, 1 p0 lo, 2 p1 hi, 3 p1 lo, 4 timer byte
  task automatic wr(input int sel, input logic [7:0] d);
    @(negedge clk);
    wr_data  = d;
    p0_hi_we = (sel == 0);
    p0_lo_we = (sel == 1);
    p1_hi_we = (sel == 2);
    p1_lo_we = (sel == 3);
    tmr_we   = (sel == 4);
    @(negedge clk);
    {p0_hi_we, p0_lo_we, p1_hi_we, p1_lo_we, tmr_we} = '0;
  endtask

  task automatic wr_rel(input int port, input logic [9:0] v);
    wr(port * 2,     {6'd0, v[9:8]});
    wr(port * 2 + 1, v[7:0]);
  endtask

  // Cycles from now until the next strobe on the chosen output.
  task automatic next_evt(input int port, input bit is_bit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sig(port, is_bit) && n < 80000);
  endtask

  // Skip two strobes, then return the clean interval to the third.
  task automatic measure(input int port, input bit is_bit, output int per);
    int n;
    next_evt(port, is_bit, n);
    next_evt(port, is_bit, n);
    next_evt(port, is_bit, per);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int per;
    int consec;

    // R2: reset state
    repeat (5) @(negedge clk);
    chk("R2 reset strobes low", int'({p0_tick16, p0_bit, p1_tick16, p1_bit}), 0);
    rst_n = 1'b1;
    measure(1, 1'b0, per);
    chk("R2 port1 interval with zero reload", per, 2048);
    measure(0, 1'b0, per);
    chk("R2 port0 interval with zero reload", per, 4096);

    // Vector table: R3, R4, R5, R9
    for (int i = 0; i < NV; i++) begin
      p0_use_tmr = VEC[i][61];
      p0_dbl     = VEC[i][60];
      wr_rel(0, VEC[i][59:50]);
      wr_rel(1, VEC[i][49:40]);
      wr(4, VEC[i][39:32]);
      measure(0, 1'b0, per);
      chk(VEC[i][61] ? "R5 port0 timer interval" : "R3 port0 generator interval",
          per, int'(VEC[i][31:16]));
      measure(1, 1'b0, per);
      chk("R4 port1 interval", per, int'(VEC[i][15:0]));
    end

    // R1: upper six bits of a hi write are ignored -> reload 0x0FF
    p0_use_tmr = 1'b0;
    p0_dbl     = 1'b0;
    wr(2, 8'hFC);
    wr(3, 8'hFF);
    measure(1, 1'b0, per);
    chk("R1 hi write keeps bits 1:0 only", per, 1538);

    // R6: write lands only at the next overflow
    wr_rel(1, 10'd0);
    measure(1, 1'b0, per);
    chk("R6 settle at zero reload", per, 2048);
    next_evt(1, 1'b0, per);
    wr(3, 8'hFF);
    wr(2, 8'h03);
    next_evt(1, 1'b0, per);
    chk_range("R6 interval after write still uses old reload", per + 4, 1000, 1100);
    next_evt(1, 1'b0, per);
    chk("R6 following interval uses new reload", per, 2);

    // R9 / R8: fastest rates and bit-period strobes
    wr_rel(0, 10'd1023);
    measure(0, 1'b0, per);
    chk("R9 port0 fastest interval", per, 4);
    measure(0, 1'b1, per);
    chk("R8 port0 bit interval", per, 64);
    measure(1, 1'b1, per);
    chk("R8 port1 bit interval", per, 32);
    p0_use_tmr = 1'b1;
    p0_dbl     = 1'b1;
    wr(4, 8'd255);
    measure(0, 1'b1, per);
    chk("R8 port0 timer bit interval", per, 192);

    // R7: no strobe lasts two cycles at the fastest rate
    consec = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (p1_tick16 && sig(1, 1'b0)) begin
        @(negedge clk);
        c++;
        if (p1_tick16) consec++;
      end
    end
    chk("R7 port1 strobe width", consec, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule